// File: doc/BRIEF.md
# Victim Line Buffer with Dirty Cast-Out Queue

This block is a small fully associative store placed next to a four-way set-associative level-one data cache. Every line the cache evicts is offered to it, whether clean or modified. A later miss in the cache searches the store by line address. On a match the line goes back to the cache and leaves the store in the same cycle. This gives a few overflowing sets one extra shared way.

The same entries also act as the cast-out queue for modified lines. Entries marked dirty are offered one at a time, oldest first, to the next memory level over a request/grant pair. A granted entry becomes clean and stays in the store as a victim line. Clean entries may be dropped to make room. Dirty entries are never dropped, so when every slot holds a dirty line the block stops accepting evictions until one of them drains.

Top module: `victim_buf`

## Requirements
- R1: While `lookup_valid_i` is high and the line address is stored, `lookup_hit_o` rises in that same cycle and `lookup_data_o` carries the stored line. `lookup_hit_o` is low whenever `lookup_valid_i` is low.
- R2: An entry that hits is removed at the clock edge ending the lookup cycle, so a repeated lookup of that address misses.
- R3: Matching compares every bit of the line address. Two addresses that share low-order (set index) bits but differ anywhere else do not match.
- R4: `lookup_dirty_o` returns the stored dirty flag of the hitting entry: 1 for a line accepted with `evict_dirty_i` high and not yet drained, 0 otherwise.
- R5: When an eviction is accepted, all slots are valid, no lookup hits in that cycle, and a clean entry exists, the oldest clean entry by acceptance order is discarded and the new line takes its slot.
- R6: When all slots hold dirty lines, `evict_ready_o` is 0. A dirty entry is never discarded.
- R7: `wb_req_o` is high while any dirty entry exists. `wb_addr_o`/`wb_data_o` present the oldest dirty entry. Each cycle with `wb_grant_i` high clears that entry's dirty flag and keeps the entry as a clean line.
- R8: If `evict_valid_i` and `lookup_valid_i` name the same address in one cycle, the lookup hits with the incoming data and dirty flag. That eviction is consumed regardless of `evict_ready_o` and is not stored.
- R9: When all slots are valid and a lookup hits in the same cycle as an accepted eviction, the new line takes the freed slot and no other entry is discarded.
- R10: After reset the store is empty, `evict_ready_o` is 1 and `wb_req_o` is 0. While free slots remain, an accepted eviction takes one and no stored line is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evict_valid_i | input | 1 | Evicted line offered |
| evict_ready_o | output | 1 | Store can take an eviction |
| evict_addr_i | input | LA_W (58) | Line address of the evicted line |
| evict_data_i | input | LINE_W (512) | Evicted line contents |
| evict_dirty_i | input | 1 | Evicted line is modified |
| lookup_valid_i | input | 1 | Lookup request from a cache miss |
| lookup_addr_i | input | LA_W (58) | Line address searched |
| lookup_hit_o | output | 1 | Lookup found the line |
| lookup_data_o | output | LINE_W (512) | Returned line |
| lookup_dirty_o | output | 1 | Returned line is modified |
| wb_req_o | output | 1 | A dirty line waits for the next level |
| wb_addr_o | output | LA_W (58) | Address of the line offered for writeback |
| wb_data_o | output | LINE_W (512) | Line offered for writeback |
| wb_grant_i | input | 1 | Next level takes the offered line this cycle |

## Verification
The assertions rely on the cache never evicting a line whose address is already in the store, so at most one entry can match any address. They also rely on an eviction being offered only while `evict_ready_o` is high, unless it is the same-address bypass. The directed scenarios build every address from distinct constants, reset between scenarios, and drive an eviction only after confirming the ready output. The single exception is the bypass test, which pairs the eviction with a lookup of the same address by design.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // where an accepted eviction lands
  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_FREE,
    SLOT_REUSE_HIT,
    SLOT_DISPLACE
  } slot_src_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N    = 4,
  parameter int LA_W = 58
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [LA_W-1:0]           key_i,
  input  logic [N-1:0]              valid_i,
  input  logic [N-1:0][LA_W-1:0]    addr_i,
  output logic [N-1:0]              match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = en_i && valid_i[g] && (addr_i[g] == key_i);
  end

  assert_unique_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_o));
endmodule

// File: rtl/vb_pick.sv
module vb_pick #(
  parameter int N     = 4,
  parameter int AGE_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][AGE_W-1:0] age_i,
  output logic [N-1:0]            sel_o,
  output logic                    any_o
);
  // oldest = largest rank among candidates
  for (genvar g = 0; g < N; g++) begin : g_sel
    always_comb begin
      sel_o[g] = cand_i[g];
      for (int j = 0; j < N; j++) begin
        if (j != g && cand_i[j] && age_i[j] > age_i[g]) sel_o[g] = 1'b0;
      end
    end
  end
  assign any_o = |cand_i;

  assert_pick_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> $onehot(sel_o));
endmodule

// File: rtl/vb_age.sv
module vb_age #(
  parameter int N     = 4,
  parameter int AGE_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0]            rm_i,
  input  logic [N-1:0]            ins_i,
  output logic [N-1:0][AGE_W-1:0] age_o
);
  logic [N-1:0][AGE_W-1:0] age_q, age_d;
  logic                    ins_any;
  logic                    age_ok;

  assign ins_any = |ins_i;

  // rank 0 = newest; ranks of valid entries stay a dense permutation
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [AGE_W:0] dec;
      logic [AGE_W:0] nxt;
      dec = '0;
      for (int j = 0; j < N; j++) begin
        if (rm_i[j] && valid_i[j] && age_q[j] < age_q[i]) dec = dec + 1'b1;
      end
      nxt = {1'b0, age_q[i]} - dec + {{AGE_W{1'b0}}, ins_any};
      if (ins_i[i])                       age_d[i] = '0;
      else if (valid_i[i] && !rm_i[i])    age_d[i] = nxt[AGE_W-1:0];
      else                                age_d[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end

  assign age_o = age_q;

  always_comb begin
    age_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (valid_i[i] && valid_i[j] && age_q[i] == age_q[j]) age_ok = 1'b0;
      end
    end
  end

  assert_age_distinct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_ok);
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int N          = 4,
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 64,
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFS_W,
  localparam int LINE_W    = 8 * LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evict_valid_i,
  output logic              evict_ready_o,
  input  logic [LA_W-1:0]   evict_addr_i,
  input  logic [LINE_W-1:0] evict_data_i,
  input  logic              evict_dirty_i,
  input  logic              lookup_valid_i,
  input  logic [LA_W-1:0]   lookup_addr_i,
  output logic              lookup_hit_o,
  output logic [LINE_W-1:0] lookup_data_o,
  output logic              lookup_dirty_o,
  output logic              wb_req_o,
  output logic [LA_W-1:0]   wb_addr_o,
  output logic [LINE_W-1:0] wb_data_o,
  input  logic              wb_grant_i
);
  import vb_pkg::*;
  localparam int AGE_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]              valid_q, dirty_q;
  logic [N-1:0][LA_W-1:0]    addr_q;
  logic [LINE_W-1:0]         data_q [N];
  logic [N-1:0][AGE_W-1:0]   age;

  logic              bypass, lk_en, stored_hit, evict_fire, wb_fire;
  logic [N-1:0]      hit_vec, free_oh, clean_oh, drain_oh, ins_oh, disp_oh, rm_oh;
  logic              any_free, any_clean;
  slot_src_e         slot_src;

  assign bypass = evict_valid_i && lookup_valid_i && (evict_addr_i == lookup_addr_i);
  assign lk_en  = lookup_valid_i && !bypass;

  vb_match #(.N(N), .LA_W(LA_W)) u_match (
    .clk_i, .rst_ni, .en_i(lk_en), .key_i(lookup_addr_i),
    .valid_i(valid_q), .addr_i(addr_q), .match_o(hit_vec)
  );

  vb_pick #(.N(N), .AGE_W(AGE_W)) u_pick_clean (
    .clk_i, .rst_ni, .cand_i(valid_q & ~dirty_q), .age_i(age),
    .sel_o(clean_oh), .any_o(any_clean)
  );

  vb_pick #(.N(N), .AGE_W(AGE_W)) u_pick_drain (
    .clk_i, .rst_ni, .cand_i(valid_q & dirty_q), .age_i(age),
    .sel_o(drain_oh), .any_o(wb_req_o)
  );

  assign stored_hit = |hit_vec;

  // lowest free slot
  always_comb begin
    free_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_q[i] && free_oh == '0) free_oh[i] = 1'b1;
    end
  end
  assign any_free = |free_oh;

  assign evict_ready_o = any_free || any_clean;
  assign evict_fire    = evict_valid_i && evict_ready_o && !bypass;
  assign wb_fire       = wb_req_o && wb_grant_i;

  always_comb begin
    if (!evict_fire)      slot_src = SLOT_NONE;
    else if (any_free)    slot_src = SLOT_FREE;
    else if (stored_hit)  slot_src = SLOT_REUSE_HIT;
    else                  slot_src = SLOT_DISPLACE;
  end

  always_comb begin
    ins_oh  = '0;
    disp_oh = '0;
    unique case (slot_src)
      SLOT_FREE:      ins_oh = free_oh;
      SLOT_REUSE_HIT: ins_oh = hit_vec;
      SLOT_DISPLACE: begin
        ins_oh  = clean_oh;
        disp_oh = clean_oh;
      end
      default: ;
    endcase
  end
  assign rm_oh = hit_vec | disp_oh;

  vb_age #(.N(N), .AGE_W(AGE_W)) u_age (
    .clk_i, .rst_ni, .valid_i(valid_q), .rm_i(rm_oh), .ins_i(ins_oh), .age_o(age)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      addr_q  <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ins_oh[i]) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= evict_dirty_i;
          addr_q[i]  <= evict_addr_i;
        end else if (rm_oh[i]) begin
          valid_q[i] <= 1'b0;
          dirty_q[i] <= 1'b0;
        end else if (wb_fire && drain_oh[i]) begin
          dirty_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N; i++) begin
      if (ins_oh[i]) data_q[i] <= evict_data_i;
    end
  end

  // response and writeback muxes (one-hot OR)
  always_comb begin
    lookup_data_o  = '0;
    lookup_dirty_o = 1'b0;
    wb_addr_o      = '0;
    wb_data_o      = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        lookup_data_o  = lookup_data_o | data_q[i];
        lookup_dirty_o = lookup_dirty_o | dirty_q[i];
      end
      if (drain_oh[i]) begin
        wb_addr_o = wb_addr_o | addr_q[i];
        wb_data_o = wb_data_o | data_q[i];
      end
    end
    if (bypass) begin
      lookup_data_o  = evict_data_i;
      lookup_dirty_o = evict_dirty_i;
    end
  end
  assign lookup_hit_o = bypass || stored_hit;

  assert_lookup_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |-> !lookup_hit_o);

  assert_hit_leaves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_hit && !evict_fire) |=> ($countones(valid_q) < $past($countones(valid_q))));

  assert_no_dirty_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(disp_oh & dirty_q)));

  assert_stall_only_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_ready_o |-> (&valid_q));

  assert_drain_progress_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_fire && !(evict_fire && evict_dirty_i))
      |=> ($countones(valid_q & dirty_q) < $past($countones(valid_q & dirty_q))));
endmodule

// File: tb/victim_buf_test.sv
module victim_buf_test;
  localparam int CLK_PERIOD = 10;
  localparam int LA_W   = 58;
  localparam int LINE_W = 512;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              evict_valid_i = 1'b0;
  logic              evict_ready_o;
  logic [LA_W-1:0]   evict_addr_i = '0;
  logic [LINE_W-1:0] evict_data_i = '0;
  logic              evict_dirty_i = 1'b0;
  logic              lookup_valid_i = 1'b0;
  logic [LA_W-1:0]   lookup_addr_i = '0;
  logic              lookup_hit_o;
  logic [LINE_W-1:0] lookup_data_o;
  logic              lookup_dirty_o;
  logic              wb_req_o;
  logic [LA_W-1:0]   wb_addr_o;
  logic [LINE_W-1:0] wb_data_o;
  logic              wb_grant_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  victim_buf uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [LINE_W-1:0] pat(input logic [LA_W-1:0] a);
    return {8{64'(a) ^ 64'h5a3c_96e1_0f0f_c3a5}};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    evict_valid_i = 1'b0; lookup_valid_i = 1'b0; wb_grant_i = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic evict(input logic [LA_W-1:0] a, input logic d);
    evict_valid_i = 1'b1; evict_addr_i = a; evict_data_i = pat(a); evict_dirty_i = d;
    step();
    evict_valid_i = 1'b0;
  endtask

  task automatic look(input string req, input logic [LA_W-1:0] a,
                      input logic exp_hit, input logic exp_dirty);
    lookup_valid_i = 1'b1; lookup_addr_i = a;
    #2;
    chk(req, 64'(lookup_hit_o), 64'(exp_hit));
    if (exp_hit) begin
      chk(req, 64'(lookup_data_o == pat(a)), 64'd1);
      chk(req, 64'(lookup_dirty_o), 64'(exp_dirty));
    end
    step();
    lookup_valid_i = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #2;
    chk("R10 ready after reset", 64'(evict_ready_o), 64'd1);
    chk("R10 no wb req after reset", 64'(wb_req_o), 64'd0);
    lookup_addr_i = 58'h77; #1;
    chk("R1 idle no hit", 64'(lookup_hit_o), 64'd0);
    look("R10 empty miss", 58'h77, 1'b0, 1'b0);
  endtask

  task automatic t_basic_hit();
    do_reset();
    evict(58'h100, 1'b0);
    evict(58'h200, 1'b0);
    evict(58'h300, 1'b0);
    look("R1 hit clean line", 58'h200, 1'b1, 1'b0);
    look("R2 removed after hit", 58'h200, 1'b0, 1'b0);
    look("R10 free slot kept line", 58'h100, 1'b1, 1'b0);
    look("R10 free slot kept line", 58'h300, 1'b1, 1'b0);
  endtask

  task automatic t_full_addr();
    do_reset();
    evict(58'h1040, 1'b0);
    look("R3 same index other tag", 58'h2040, 1'b0, 1'b0);
    look("R3 low bit differs", 58'h1041, 1'b0, 1'b0);
    look("R3 exact match", 58'h1040, 1'b1, 1'b0);
  endtask

  task automatic t_dirty_back();
    do_reset();
    evict(58'h5000, 1'b1);
    #1;
    chk("R7 req with dirty entry", 64'(wb_req_o), 64'd1);
    look("R4 dirty returned", 58'h5000, 1'b1, 1'b1);
    #1;
    chk("R7 no req after dirty hit", 64'(wb_req_o), 64'd0);
  endtask

  task automatic t_displace();
    do_reset();
    evict(58'hc0, 1'b0);
    evict(58'hc1, 1'b1);
    evict(58'hc2, 1'b0);
    evict(58'hc3, 1'b0);
    #1;
    chk("R5 ready with clean entry", 64'(evict_ready_o), 64'd1);
    evict(58'hc4, 1'b0);
    look("R5 oldest clean gone", 58'hc0, 1'b0, 1'b0);
    look("R6 dirty kept", 58'hc1, 1'b1, 1'b1);
    look("R5 newer clean kept", 58'hc2, 1'b1, 1'b0);
    look("R5 new line stored", 58'hc4, 1'b1, 1'b0);
  endtask

  task automatic grant_one(input string req, input logic [LA_W-1:0] exp_a);
    #1;
    chk(req, 64'(wb_req_o), 64'd1);
    chk(req, 64'(wb_addr_o), 64'(exp_a));
    chk(req, 64'(wb_data_o == pat(exp_a)), 64'd1);
    wb_grant_i = 1'b1;
    step();
    wb_grant_i = 1'b0;
  endtask

  task automatic t_all_dirty();
    do_reset();
    evict(58'hd0, 1'b1);
    evict(58'hd1, 1'b1);
    evict(58'hd2, 1'b1);
    evict(58'hd3, 1'b1);
    #1;
    chk("R6 stall when all dirty", 64'(evict_ready_o), 64'd0);
    grant_one("R7 drain first", 58'hd0);
    #1;
    chk("R6 ready after a drain", 64'(evict_ready_o), 64'd1);
    evict(58'he0, 1'b0);
    grant_one("R7 drain second", 58'hd1);
    grant_one("R7 drain third", 58'hd2);
    grant_one("R7 drain fourth", 58'hd3);
    #1;
    chk("R7 req drops when clean", 64'(wb_req_o), 64'd0);
    look("R6 drained line displaced", 58'hd0, 1'b0, 1'b0);
    look("R7 drained line kept clean", 58'hd2, 1'b1, 1'b0);
    look("R5 inserted line present", 58'he0, 1'b1, 1'b0);
  endtask

  task automatic t_bypass();
    do_reset();
    evict_valid_i = 1'b1; evict_addr_i = 58'hf00; evict_data_i = pat(58'hf00);
    evict_dirty_i = 1'b1;
    lookup_valid_i = 1'b1; lookup_addr_i = 58'hf00;
    #2;
    chk("R8 bypass hit", 64'(lookup_hit_o), 64'd1);
    chk("R8 bypass data", 64'(lookup_data_o == pat(58'hf00)), 64'd1);
    chk("R8 bypass dirty", 64'(lookup_dirty_o), 64'd1);
    step();
    evict_valid_i = 1'b0; lookup_valid_i = 1'b0;
    #1;
    chk("R8 bypass not queued", 64'(wb_req_o), 64'd0);
    look("R8 bypass not stored", 58'hf00, 1'b0, 1'b0);
  endtask

  task automatic t_reuse_slot();
    do_reset();
    evict(58'h10, 1'b0);
    evict(58'h11, 1'b0);
    evict(58'h12, 1'b0);
    evict(58'h13, 1'b0);
    evict_valid_i = 1'b1; evict_addr_i = 58'h20; evict_data_i = pat(58'h20);
    evict_dirty_i = 1'b0;
    lookup_valid_i = 1'b1; lookup_addr_i = 58'h13;
    #2;
    chk("R9 hit during eviction", 64'(lookup_hit_o), 64'd1);
    step();
    evict_valid_i = 1'b0; lookup_valid_i = 1'b0;
    look("R9 oldest not displaced", 58'h10, 1'b1, 1'b0);
    look("R9 other kept", 58'h11, 1'b1, 1'b0);
    look("R9 other kept", 58'h12, 1'b1, 1'b0);
    look("R9 new line in freed slot", 58'h20, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_basic_hit();
    t_full_addr();
    t_dirty_back();
    t_displace();
    t_all_dirty();
    t_bypass();
    t_reuse_slot();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule